// File: doc/BRIEF.md
# Command Byte Interpreter with Nibble Queue

This block turns a stream of one-byte commands into register transfers. Two byte sources feed it: a host serial link and a keypad encoder. Both offer a byte with a valid flag. The block merges them by bitwise OR into a single accepted byte, so a source that stays idle has no effect on the other. Digit bytes shift a 4-bit value into a four-deep nibble queue, newest nibble at the least significant end. The queue contents are always visible so that they can be shown on a display. An action byte copies the queued 16-bit word onto the transfer output, raises a one-cycle strobe for the chosen destination and empties the queue.

Two encodings are supported, and a mode pin selects between them. The binary encoding splits each byte into a kind nibble and an argument nibble. The text encoding lets a terminal drive the block directly: hex characters enter digits, and four letters pick the destinations. The input is a valid/ready stream. The block never applies back-pressure once reset is over: ready stays high and every valid byte is taken on the clock edge where it is presented. A source therefore never has to hold a byte for longer than one cycle. While ready is low during reset, offered bytes are dropped.

Top module: `cmd_nibble_fifo`

## Requirements
- R1: During reset and on the first cycle after it, `queue_nibbles`, `tgt_strobe` and `xfer_value` are zero. `in_ready` is low in reset and goes high one clock edge after reset is released.
- R2: In binary mode (`ascii_mode`=0), a byte 0x1N is a digit. On the next edge the queue becomes `{old[11:0], N}`.
- R3: Digits enter most significant first: the digits A, B, C, D give 0xABCD. A fifth digit drops the oldest nibble, so 1,2,3,4,5 gives 0x2345.
- R4: In binary mode, a byte 0x2T with T in 0..3 is an action. On the next edge `tgt_strobe` equals 1<<T for exactly one cycle, and `xfer_value` takes the queue word. Destination index 0 is the first read-address latch, 1 the second read-address latch, 2 the result address and 3 the result data.
- R5: The edge that performs an action clears the queue. An action taken after fewer than four digits transfers a word whose upper nibbles are zero.
- R6: In text mode (`ascii_mode`=1), the characters 0x30-0x39 give digits 0-9. The characters 0x41-0x46 and 0x61-0x66 give digits 10-15.
- R7: In text mode, 'r' (0x72) acts on index 0, 'R' (0x52) on index 1, 'W' (0x57) on index 2 and 'w' (0x77) on index 3.
- R8: Any other byte leaves the queue, `xfer_value` and strobes unchanged. This covers binary kinds 0x0 and 0x3-0xF, actions with T>3, other characters in text mode, and binary codes offered in text mode.
- R9: When both sources are valid in the same cycle, the interpreted byte is the bitwise OR of the two bytes. A source without valid contributes zero.
- R10: When neither source is valid, all outputs hold and no strobe is raised, so a strobe never lasts two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ascii_mode | input | 1 | 1 selects the text encoding, 0 the binary encoding |
| host_valid | input | 1 | Host link byte valid |
| host_data | input | 8 | Host link byte |
| key_valid | input | 1 | Keypad byte valid |
| key_data | input | 8 | Keypad byte |
| in_ready | output | 1 | Shared ready for both sources, high after reset |
| queue_nibbles | output | 16 | Queued nibbles, newest in bits 3:0 |
| tgt_strobe | output | 4 | One-cycle strobe per destination index |
| xfer_value | output | 16 | Word carried by the latest action |

## Verification
A corrupted queue appears on `queue_nibbles` at the edge after the bad byte, because the queue drives that port directly. A wrong decode shows either as a digit that is not entered or as a strobe on the wrong bit, also one edge later. A stale word or a clear that fails to happen becomes visible at the next action, through `xfer_value` and a non-zero queue. The bench's reference model compares all three outputs after every edge, so any divergence is caught in the cycle it appears.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_DIGIT  = 2'd1,
    OP_ACTION = 2'd2
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [3:0] arg;
  } cmd_t;

  localparam logic [3:0] KIND_DIGIT  = 4'h1;
  localparam logic [3:0] KIND_ACTION = 4'h2;
endpackage

// File: rtl/cbi_decode.sv
module cbi_decode
  import cbi_pkg::*;
#(
  parameter int TGT_N   = 4,
  parameter bit TEXT_EN = 1'b1
) (
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  input  logic       text_i,
  output cmd_t       cmd_o
);
  cmd_t bin_cmd;
  cmd_t txt_cmd;

  always_comb begin
    bin_cmd = '{op: OP_NONE, arg: byte_i[3:0]};
    if (byte_i[7:4] == KIND_DIGIT)
      bin_cmd.op = OP_DIGIT;
    else if (byte_i[7:4] == KIND_ACTION && int'(byte_i[3:0]) < TGT_N)
      bin_cmd.op = OP_ACTION;
  end

  generate
    if (TEXT_EN) begin : g_text
      always_comb begin
        txt_cmd = '{op: OP_NONE, arg: 4'h0};
        if (byte_i >= 8'h30 && byte_i <= 8'h39) begin
          txt_cmd.op  = OP_DIGIT;
          txt_cmd.arg = byte_i[3:0];
        end else if ((byte_i >= 8'h41 && byte_i <= 8'h46) ||
                     (byte_i >= 8'h61 && byte_i <= 8'h66)) begin
          txt_cmd.op  = OP_DIGIT;
          txt_cmd.arg = byte_i[3:0] + 4'd9;
        end else begin
          case (byte_i)
            8'h72: txt_cmd = '{op: OP_ACTION, arg: 4'd0};
            8'h52: txt_cmd = '{op: OP_ACTION, arg: 4'd1};
            8'h57: txt_cmd = '{op: OP_ACTION, arg: 4'd2};
            8'h77: txt_cmd = '{op: OP_ACTION, arg: 4'd3};
            default: txt_cmd = '{op: OP_NONE, arg: 4'h0};
          endcase
        end
      end
    end else begin : g_no_text
      assign txt_cmd = '{op: OP_NONE, arg: 4'h0};
    end
  endgenerate

  always_comb begin
    if (!valid_i)     cmd_o = '{op: OP_NONE, arg: 4'h0};
    else if (text_i)  cmd_o = txt_cmd;
    else              cmd_o = bin_cmd;
  end
endmodule

// File: rtl/cbi_queue.sv
module cbi_queue #(
  parameter int NIB_W = 4,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_i,
  input  logic [NIB_W-1:0]       nib_i,
  input  logic                   clr_i,
  output logic [NIB_W*DEPTH-1:0] q_o
);
  localparam int QW = NIB_W * DEPTH;

  logic [QW-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr_i)  q <= '0;
    else if (push_i) q <= {q[QW-NIB_W-1:0], nib_i};
  end

  assign q_o = q;

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i) |=> (q[NIB_W-1:0] == $past(nib_i)) &&
                           (q[QW-1:NIB_W] == $past(q[QW-NIB_W-1:0])));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (q == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/cbi_xfer.sv
module cbi_xfer #(
  parameter int VAL_W = 16,
  parameter int TGT_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [3:0]       sel_i,
  input  logic [VAL_W-1:0] value_i,
  output logic [TGT_N-1:0] strobe_o,
  output logic [VAL_W-1:0] value_o
);
  generate
    for (genvar t = 0; t < TGT_N; t++) begin : g_tgt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_o[t] <= 1'b0;
        else        strobe_o[t] <= fire_i && (sel_i == 4'(t));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value_o <= '0;
    else if (fire_i) value_o <= value_i;
  end

  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_o));

  assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> (strobe_o == '0) && $stable(value_o));
endmodule

// File: rtl/cmd_nibble_fifo.sv
module cmd_nibble_fifo
  import cbi_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int DEPTH   = 4,
  parameter int TGT_N   = 4,
  parameter bit TEXT_EN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ascii_mode,
  input  logic                   host_valid,
  input  logic [7:0]             host_data,
  input  logic                   key_valid,
  input  logic [7:0]             key_data,
  output logic                   in_ready,
  output logic [NIB_W*DEPTH-1:0] queue_nibbles,
  output logic [TGT_N-1:0]       tgt_strobe,
  output logic [NIB_W*DEPTH-1:0] xfer_value
);
  localparam int QW = NIB_W * DEPTH;

  logic       ready_q;
  logic       accept;
  logic [7:0] merged;
  cmd_t       cmd;
  logic       do_digit;
  logic       do_action;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign in_ready = ready_q;

  assign accept = ready_q && (host_valid || key_valid);
  assign merged = (host_valid ? host_data : 8'h00) | (key_valid ? key_data : 8'h00);

  cbi_decode #(.TGT_N(TGT_N), .TEXT_EN(TEXT_EN)) i_decode (
    .valid_i (accept),
    .byte_i  (merged),
    .text_i  (ascii_mode),
    .cmd_o   (cmd)
  );

  assign do_digit  = (cmd.op == OP_DIGIT);
  assign do_action = (cmd.op == OP_ACTION);

  cbi_queue #(.NIB_W(NIB_W), .DEPTH(DEPTH)) i_queue (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (do_digit),
    .nib_i  (cmd.arg[NIB_W-1:0]),
    .clr_i  (do_action),
    .q_o    (queue_nibbles)
  );

  cbi_xfer #(.VAL_W(QW), .TGT_N(TGT_N)) i_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (do_action),
    .sel_i    (cmd.arg),
    .value_i  (queue_nibbles),
    .strobe_o (tgt_strobe),
    .value_o  (xfer_value)
  );

  assert_strobe_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_strobe != '0) |-> (queue_nibbles == '0));

  assert_strobe_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_strobe != '0) |-> (xfer_value == $past(queue_nibbles)));

  assert_no_take_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_q |=> $stable(queue_nibbles) && (tgt_strobe == '0));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_valid && !key_valid) |=> $stable(queue_nibbles) && (tgt_strobe == '0));
endmodule

// File: tb/test_cmd_nibble_fifo.sv
`timescale 1ns/1ps
module test_cmd_nibble_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ascii_mode = 1'b0;
  logic        host_valid = 1'b0;
  logic [7:0]  host_data = 8'h00;
  logic        key_valid = 1'b0;
  logic [7:0]  key_data = 8'h00;
  logic        in_ready;
  logic [15:0] queue_nibbles;
  logic [3:0]  tgt_strobe;
  logic [15:0] xfer_value;

  int total = 0;
  int bad = 0;
  int m_q = 0;
  int m_x = 0;
  int m_s = 0;

  always #2 clk = ~clk;

  cmd_nibble_fifo i_cmd_nibble_fifo (
    .clk(clk), .rst_n(rst_n), .ascii_mode(ascii_mode),
    .host_valid(host_valid), .host_data(host_data),
    .key_valid(key_valid), .key_data(key_data),
    .in_ready(in_ready), .queue_nibbles(queue_nibbles),
    .tgt_strobe(tgt_strobe), .xfer_value(xfer_value)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference interpretation: returns kind (0 none, 1 digit, 2 action) and arg
  task automatic interpret(input int b, input bit txt, output int kind, output int arg);
    kind = 0; arg = 0;
    if (!txt) begin
      if (b / 16 == 1) begin kind = 1; arg = b % 16; end
      else if (b / 16 == 2 && b % 16 < 4) begin kind = 2; arg = b % 16; end
    end else begin
      if (b >= "0" && b <= "9") begin kind = 1; arg = b - "0"; end
      else if (b >= "A" && b <= "F") begin kind = 1; arg = b - "A" + 10; end
      else if (b >= "a" && b <= "f") begin kind = 1; arg = b - "a" + 10; end
      else if (b == "r") begin kind = 2; arg = 0; end
      else if (b == "R") begin kind = 2; arg = 1; end
      else if (b == "W") begin kind = 2; arg = 2; end
      else if (b == "w") begin kind = 2; arg = 3; end
    end
  endtask

  task automatic cycle(string req, bit hv, int hb, bit kv, int kb);
    int kind, arg, b;
    host_valid = hv; host_data = 8'(hb);
    key_valid = kv; key_data = 8'(kb);
    m_s = 0;
    if (hv || kv) begin
      b = (hv ? hb : 0) | (kv ? kb : 0);
      interpret(b, ascii_mode, kind, arg);
      if (kind == 1) m_q = ((m_q * 16) + arg) % 65536;
      else if (kind == 2) begin m_s = 1 << arg; m_x = m_q; m_q = 0; end
    end
    @(negedge clk);
    check(req, "queue", int'(queue_nibbles), m_q);
    check(req, "strobe", int'(tgt_strobe), m_s);
    check(req, "xfer", int'(xfer_value), m_x);
  endtask

  task automatic hbyte(string req, int b);
    cycle(req, 1'b1, b, 1'b0, 0);
  endtask

  task automatic idle(string req);
    cycle(req, 1'b0, 0, 1'b0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", int'(in_ready), 0);
    check("R1", "queue in reset", int'(queue_nibbles), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", int'(in_ready), 1);
    check("R1", "strobe", int'(tgt_strobe), 0);
    check("R1", "xfer", int'(xfer_value), 0);

    // R2 R3 R4 R5: worked example sequence
    hbyte("R2", 8'h12);
    hbyte("R4", 8'h22);
    idle("R10");
    hbyte("R3", 8'h1A); hbyte("R3", 8'h1B); hbyte("R3", 8'h1C); hbyte("R3", 8'h1D);
    hbyte("R4", 8'h23);
    idle("R10");
    // R5: short entry leaves upper nibbles zero
    hbyte("R5", 8'h17);
    hbyte("R5", 8'h20);
    // R3: overflow drops oldest
    for (int i = 1; i <= 5; i++) hbyte("R3", 8'h10 + i);
    hbyte("R4", 8'h21);
    // R8: ignored binary codes with a non-empty queue
    hbyte("R2", 8'h1E);
    hbyte("R8", 8'h35); hbyte("R8", 8'h05); hbyte("R8", 8'h24);
    hbyte("R8", 8'h2F); hbyte("R8", 8'hF1); hbyte("R8", 8'h31);
    idle("R10"); idle("R10");
    // R9: both sources ORed
    cycle("R9", 1'b1, 8'h10, 1'b1, 8'h09);
    cycle("R9", 1'b0, 8'hFF, 1'b1, 8'h14);
    cycle("R9", 1'b1, 8'h20, 1'b1, 8'h03);
    // text mode
    ascii_mode = 1'b1;
    hbyte("R6", "1"); hbyte("R6", "a"); hbyte("R6", "F"); hbyte("R6", "9");
    hbyte("R7", "w");
    hbyte("R6", "0"); hbyte("R6", "c"); hbyte("R6", "E");
    hbyte("R8", "x"); hbyte("R8", 8'h12); hbyte("R8", "G"); hbyte("R8", 8'h0A);
    hbyte("R7", "W");
    hbyte("R6", "7");
    hbyte("R7", "r");
    hbyte("R7", "R");
    idle("R10");
    ascii_mode = 1'b0;
    hbyte("R8", "w");
    hbyte("R2", 8'h13);
    hbyte("R4", 8'h22);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule